// File: doc/BRIEF.md
# Next Program Counter Selector

This block owns the program counter of a single-cycle processor core and decides, every clock, which address the core fetches next. It forms the sequential address (current PC plus 4), a PC-relative branch target and a region-relative absolute jump target. It then passes them through a fixed chain of three selection stages. The first stage picks between sequential and branch. The second lets a register value override that. The third lets the absolute jump override everything.

The decoder supplies four control strobes: branch-if-equal, branch-if-not-equal, jump and jump-through-register. The ALU supplies its zero flag. The register file supplies the value read on its first read port. The block needs only the low 26 bits of the instruction. The low 16 of these form the branch offset, and all 26 form the jump field. The PC register resets synchronously to a parameterised address, which defaults to 0.

Top module: `next_pc_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes RESET_ADDR (default 0) after that edge.
- R2: With all four control strobes low, `pc_next` equals `pc + 4`, and `pc` takes that value at the next edge.
- R3: With `br_eq` high and `zero` high, the branch is taken. `pc_next` is `pc + 4` plus `ins_low[15:0]` sign-extended to 32 bits and shifted left by 2, so offsets with bit 15 set move backwards.
- R4: With `br_ne` high and `zero` low, the branch is taken, with the same target as R3.
- R5: A branch strobe whose zero condition fails (`br_eq` with `zero` low, or `br_ne` with `zero` high) has no effect, and `pc_next` is `pc + 4`.
- R6: With `jmp_reg` high and `jmp` low, `pc_next` equals `rs_val`, whatever the branch strobes and `zero` are.
- R7: With `jmp` high, `pc_next` is `{(pc+4)[31:28], ins_low[25:0], 2'b00}`, whatever `jmp_reg`, the branch strobes and `zero` are. The top nibble is taken after the increment, so a carry into bit 28 shows up in the target.
- R8: Out of reset, `pc` after each rising edge equals the `pc_next` value presented before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ins_low | input | 26 | Low 26 bits of the current instruction |
| rs_val | input | 32 | Value read on register port 1, used as the register jump target |
| zero | input | 1 | ALU zero flag |
| br_eq | input | 1 | Branch-if-equal strobe |
| br_ne | input | 1 | Branch-if-not-equal strobe |
| jmp | input | 1 | Absolute jump strobe |
| jmp_reg | input | 1 | Jump-through-register strobe |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address the PC takes at the next edge |

## Verification
Straight-line steps with no strobes show that the register increments by exactly 4. Each branch strobe is driven with both values of `zero`, which tells a taken branch from a silently ignored one, and positive and negative offsets expose a missing sign extension. Steps with several strobes high at once (branch with register jump, register jump with absolute jump) pin down the order of the selection chain. A register jump to just below a 256 MB boundary followed by an absolute jump shows whether the jump nibble comes from `pc` or from `pc + 4`.

// File: rtl/next_pc_sel.sv
module next_pc_sel #(
  parameter int          AW         = 32,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [25:0]   ins_low,
  input  logic [AW-1:0] rs_val,
  input  logic          zero,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          jmp,
  input  logic          jmp_reg,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_next
);
  localparam int SEXT = AW - 18;

  logic [AW-1:0] seq_addr, br_off, br_tgt, jmp_tgt, stage1, stage2;
  logic          take_br;

  assign seq_addr = pc + AW'(4);
  assign br_off   = {{SEXT{ins_low[15]}}, ins_low[15:0], 2'b00};
  assign br_tgt   = seq_addr + br_off;
  assign jmp_tgt  = {seq_addr[AW-1:28], ins_low, 2'b00};
  assign take_br  = (br_eq & zero) | (br_ne & ~zero);

  assign stage1  = take_br ? br_tgt  : seq_addr;
  assign stage2  = jmp_reg ? rs_val  : stage1;
  assign pc_next = jmp     ? jmp_tgt : stage2;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_ADDR[AW-1:0];
    else     pc <= pc_next;
  end
endmodule

module next_pc_sel_chk #(
  parameter int          AW         = 32,
  parameter logic [31:0] RESET_ADDR = 32'h0
) (
  input logic          clk,
  input logic          rst,
  input logic          zero,
  input logic          br_eq,
  input logic          br_ne,
  input logic          jmp,
  input logic          jmp_reg,
  input logic [AW-1:0] rs_val,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] pc_next
);
  logic [AW-1:0] inc;
  assign inc = pc + AW'(4);

  a_r1_reset_addr: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> pc == RESET_ADDR[AW-1:0]);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    !(br_eq || br_ne || jmp || jmp_reg) |-> pc_next == inc);

  a_r5_branch_ignored: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !jmp_reg && ((br_eq && !zero && !br_ne) || (br_ne && zero && !br_eq)))
      |-> pc_next == inc);

  a_r6_reg_jump: assert property (@(posedge clk) disable iff (rst)
    (jmp_reg && !jmp) |-> pc_next == rs_val);

  a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
    jmp |-> (pc_next[1:0] == 2'b00 && pc_next[AW-1:28] == inc[AW-1:28]));

  a_r8_pc_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(pc_next));
endmodule

bind next_pc_sel next_pc_sel_chk #(.AW(AW), .RESET_ADDR(RESET_ADDR)) chk (
  .clk(clk), .rst(rst), .zero(zero), .br_eq(br_eq), .br_ne(br_ne),
  .jmp(jmp), .jmp_reg(jmp_reg), .rs_val(rs_val), .pc(pc), .pc_next(pc_next)
);

// File: tb/tb_next_pc_sel.sv
module tb_next_pc_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] ins_low = '0;
  logic [31:0] rs_val = '0;
  logic        zero = 1'b0, br_eq = 1'b0, br_ne = 1'b0, jmp = 1'b0, jmp_reg = 1'b0;
  logic [31:0] pc, pc_next;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_pc = 32'h0;

  always #4 clk = ~clk;

  next_pc_sel dut (
    .clk(clk), .rst(rst), .ins_low(ins_low), .rs_val(rs_val), .zero(zero),
    .br_eq(br_eq), .br_ne(br_ne), .jmp(jmp), .jmp_reg(jmp_reg),
    .pc(pc), .pc_next(pc_next)
  );

  function automatic logic [31:0] predict(logic [31:0] cur, logic [25:0] il, logic [31:0] rv,
                                          logic z, logic be, logic bn, logic j, logic jr);
    logic [31:0] s;
    s = cur + 32'd4;
    if (j)  return {s[31:28], il, 2'b00};
    if (jr) return rv;
    if ((be && z) || (bn && !z)) return s + {{14{il[15]}}, il[15:0], 2'b00};
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic r, logic [25:0] il, logic [31:0] rv,
                      logic z, logic be, logic bn, logic j, logic jr);
    logic [31:0] e;
    @(negedge clk);
    #1;
    rst = r; ins_low = il; rs_val = rv; zero = z;
    br_eq = be; br_ne = bn; jmp = j; jmp_reg = jr;
    e = r ? 32'h0 : predict(model_pc, il, rv, z, be, bn, j, jr);
    #1;
    if (!r) check({req, "/R8 comb"}, pc_next, e);
    model_pc = e;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc, e);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", pc, 32'h0);
    step("R1", 1, 26'h0, 32'h0, 0, 0, 0, 0, 0);
    step("R2 seq", 0, 26'h3FFFFFF, 32'hDEAD, 1, 0, 0, 0, 0);
    step("R2 seq", 0, 26'h0, 32'h0, 0, 0, 0, 0, 0);
    step("R3 beq fwd", 0, 26'h0010, 32'h0, 1, 1, 0, 0, 0);
    step("R3 beq back", 0, 26'h3FFFFFE, 32'h0, 1, 1, 0, 0, 0);
    step("R4 bne taken", 0, 26'h0003, 32'h0, 0, 0, 1, 0, 0);
    step("R5 beq not zero", 0, 26'h0040, 32'h0, 0, 1, 0, 0, 0);
    step("R5 bne zero", 0, 26'h0040, 32'h0, 1, 0, 1, 0, 0);
    step("R6 jr over branch", 0, 26'h0020, 32'h0000_1230, 1, 1, 0, 0, 1);
    step("R6 jr", 0, 26'h0, 32'h0FFF_FFF8, 0, 0, 0, 0, 1);
    step("R2 seq", 0, 26'h0, 32'h0, 0, 0, 0, 0, 0);
    step("R7 jump carry nibble", 0, 26'h0000_100, 32'h0, 0, 0, 0, 1, 0);
    step("R6 jr high", 0, 26'h0, 32'hF000_0010, 0, 0, 0, 0, 1);
    step("R7 jump over jr+branch", 0, 26'h2AB_CDEF, 32'h1111_1110, 1, 1, 0, 1, 1);
    step("R4 bne back", 0, 26'h000_8000, 32'h0, 0, 0, 1, 0, 0);
    step("R1 mid reset", 1, 26'h0, 32'h0, 0, 0, 0, 1, 0);
    step("R8 after reset", 0, 26'h0, 32'h0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++)
      step("R8 mix", 0, 26'(i * 37), 32'(i * 64), i[0], i[1], i[2], 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule